// File: doc/BRIEF.md
# Test-Access-Port Instruction Decoder with Data Registers

This block sits behind a test access port state machine and holds the 6-bit instruction register together with every data register that the instruction can place between the serial input and the serial output. The state machine provides one strobe per cycle for capture, shift and update of the instruction path, capture and shift of the data path, and a test-logic reset. The block returns a single serial output that is retimed on the falling clock edge. The active instruction picks one of eight shift registers: a 1-bit bypass, a 32-bit identification code, a 12-bit status word, a 16-bit user signature, a 4-bit configuration address, a 41-bit configuration data word, a 75-bit array address and an 81-bit array data word.

No boundary-scan chain exists. The external-test and sample codes, every code with its most significant bit set, and every code that has no register of its own all shift through bypass. A small three-state mode machine (IO_NORMAL, IO_SAFE, IO_PROG) drives two flags. `safe_state` tells the pins to float with their FET drivers held low. `prog_mode` marks programming mode. The machine moves only on an instruction update. These are its transitions: from any state, program-enable goes to IO_PROG and program-disable goes to IO_NORMAL. IO_NORMAL goes to IO_SAFE on the safe-state code or on any erase or write code. All other codes keep the current state. Reset returns it to IO_NORMAL.

Top module: `tap_instr_decoder`

## Requirements
- R1: The instruction register is 6 bits and shifts least significant bit first. A capture-IR strobe loads 000001, so the first two bits that come out are 1 then 0, followed by zeros.
- R2: A shifted instruction takes effect only on the update-IR strobe. Until then, shifting leaves the selected data register unchanged.
- R3: Asynchronous `trst_n` low, or the synchronous `tlr` strobe, loads the identification code 011001 as the active instruction, clears every data register and clears both flags.
- R4: Code 011001 selects the 32-bit identification register, which captures `IDCODE_VAL`. Code 011011 selects the 12-bit status register, which captures `status_in`. Code 011110 selects the 16-bit signature register, which captures `sig_in`.
- R5: Code 001010 selects the 4-bit configuration address. Codes 001011 and 001110 select the 41-bit configuration data. Code 000001 selects the 75-bit array address. Codes 000010 and 001000 select the 81-bit array data. These four registers keep their contents on capture, so data shifted in reads back out on the next scan.
- R6: Codes 000111, 000000 and 011100, every code of the form 1xxxxx, and every code not named in R4 or R5 select the 1-bit bypass register, which captures 0.
- R7: Data registers take `tdi` at the most significant end and present their least significant bit. `tdo` is updated on the falling edge and is 0 in any cycle without a shift strobe.
- R8: Code 011000 sets both `prog_mode` and `safe_state`. Code 011010 clears both.
- R9: Code 010111 and the erase/write codes 000011, 000100, 000101, 000110, 001100, 001101, 010110, 011101 and 011111 set `safe_state` without changing `prog_mode`. `safe_state` then stays set until code 011010 or a reset.
- R10: Every other code, including 011001, leaves both flags unchanged.
- R11: `prog_mode` is never high while `safe_state` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset strobe |
| capture_ir | input | 1 | Capture-IR strobe |
| shift_ir | input | 1 | Shift-IR strobe |
| update_ir | input | 1 | Update-IR strobe |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| tdi | input | 1 | Serial data in |
| status_in | input | STAT_W | Status word sampled on capture |
| sig_in | input | SIG_W | User signature sampled on capture |
| tdo | output | 1 | Serial data out, falling-edge retimed |
| safe_state | output | 1 | Pins held floating, FET drivers low |
| prog_mode | output | 1 | Programming mode active |

## Verification
The in-line assertions check properties that hold on every cycle. They cover the capture pattern of the instruction register, a stable active instruction while no update arrives, the identification code after a reset strobe, the zero loaded into bypass, status sampling, program mode implying safe state, the stickiness of safe state, and program-disable clearing both flags. Other properties need scenarios that only the bench drives. These are the register length and capture value behind each of the 64 codes, read-back of the holding registers, the serial bit order, and flag sequences such as an erase code issued inside program mode.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    localparam int IR_W = 6;
    typedef logic [IR_W-1:0] op_t;

    // codes whose value the decoder relies on
    localparam op_t OP_EXT        = 6'b000000;
    localparam op_t OP_ARR_ADDR   = 6'b000001;
    localparam op_t OP_ARR_DATA   = 6'b000010;
    localparam op_t OP_ERASE_A    = 6'b000011;
    localparam op_t OP_ERASE_B    = 6'b000100;
    localparam op_t OP_WRITE_ARR  = 6'b000101;
    localparam op_t OP_WRITE_FUSE = 6'b000110;
    localparam op_t OP_BYPASS     = 6'b000111;
    localparam op_t OP_ARR_READ   = 6'b001000;
    localparam op_t OP_CFG_ADDR   = 6'b001010;
    localparam op_t OP_CFG_DATA   = 6'b001011;
    localparam op_t OP_ERASE_CFG  = 6'b001100;
    localparam op_t OP_WRITE_CFG  = 6'b001101;
    localparam op_t OP_CFG_READ   = 6'b001110;
    localparam op_t OP_ERASE_ALL  = 6'b010110;
    localparam op_t OP_SAFE       = 6'b010111;
    localparam op_t OP_PROG_ON    = 6'b011000;
    localparam op_t OP_IDENT      = 6'b011001;
    localparam op_t OP_PROG_OFF   = 6'b011010;
    localparam op_t OP_STATUS     = 6'b011011;
    localparam op_t OP_SAMPLE     = 6'b011100;
    localparam op_t OP_ERASE_SIG  = 6'b011101;
    localparam op_t OP_SIG_READ   = 6'b011110;
    localparam op_t OP_WRITE_SIG  = 6'b011111;

    localparam op_t IR_CAPTURE_PAT = 6'b000001;

    typedef enum logic [2:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_STATUS,
        SEL_SIG,
        SEL_CADDR,
        SEL_CDATA,
        SEL_AADDR,
        SEL_ADATA
    } dsel_e;

    typedef enum logic [1:0] {
        IO_NORMAL,
        IO_SAFE,
        IO_PROG
    } iomode_e;

    function automatic dsel_e op_to_sel(op_t op);
        dsel_e s;
        if (op[IR_W-1]) begin
            s = SEL_BYPASS;
        end else begin
            case (op)
                OP_IDENT:                  s = SEL_IDCODE;
                OP_STATUS:                 s = SEL_STATUS;
                OP_SIG_READ:               s = SEL_SIG;
                OP_CFG_ADDR:               s = SEL_CADDR;
                OP_CFG_DATA, OP_CFG_READ:  s = SEL_CDATA;
                OP_ARR_ADDR:               s = SEL_AADDR;
                OP_ARR_DATA, OP_ARR_READ:  s = SEL_ADATA;
                default:                   s = SEL_BYPASS;
            endcase
        end
        return s;
    endfunction

    function automatic logic op_forces_safe(op_t op);
        logic f;
        case (op)
            OP_SAFE, OP_ERASE_A, OP_ERASE_B, OP_WRITE_ARR, OP_WRITE_FUSE,
            OP_ERASE_CFG, OP_WRITE_CFG, OP_ERASE_ALL, OP_ERASE_SIG,
            OP_WRITE_SIG:              f = 1'b1;
            default:                   f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tdec_ir.sv
module tdec_ir
    import tdec_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tlr,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic ir_so,
    output op_t  op_pending,
    output op_t  op_active
);

    op_t sh_q;
    op_t act_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= IR_CAPTURE_PAT;
        end else if (tlr) begin
            sh_q <= IR_CAPTURE_PAT;
        end else if (capture) begin
            sh_q <= IR_CAPTURE_PAT;
        end else if (shift) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            act_q <= OP_IDENT;
        end else if (tlr) begin
            act_q <= OP_IDENT;
        end else if (update && !capture && !shift) begin
            act_q <= sh_q;
        end
    end

    assign ir_so      = sh_q[0];
    assign op_pending = sh_q;
    assign op_active  = act_q;

    a_r1_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (capture && !tlr) |=> (op_pending == 6'b000001));

    a_r2_hold_until_update: assert property (@(posedge tck) disable iff (!trst_n)
        (!update && !tlr) |=> $stable(op_active));

    a_r3_reset_ident: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (op_active == OP_IDENT));

endmodule

// File: rtl/tdec_mode.sv
module tdec_mode
    import tdec_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tlr,
    input  logic update,
    input  op_t  op_new,
    output logic safe_state,
    output logic prog_mode
);

    iomode_e st_q;
    iomode_e st_n;
    logic    go_prog;
    logic    go_off;
    logic    go_safe;

    assign go_prog = update && (op_new == OP_PROG_ON);
    assign go_off  = update && (op_new == OP_PROG_OFF);
    assign go_safe = update && op_forces_safe(op_new);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            IO_NORMAL: begin
                if (go_prog)      st_n = IO_PROG;
                else if (go_safe) st_n = IO_SAFE;
            end
            IO_SAFE: begin
                if (go_prog)      st_n = IO_PROG;
                else if (go_off)  st_n = IO_NORMAL;
            end
            IO_PROG: begin
                if (go_off)       st_n = IO_NORMAL;
            end
            default:              st_n = IO_NORMAL;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= IO_NORMAL;
        end else if (tlr) begin
            st_q <= IO_NORMAL;
        end else begin
            st_q <= st_n;
        end
    end

    always_comb begin
        unique case (st_q)
            IO_SAFE: begin
                safe_state = 1'b1;
                prog_mode  = 1'b0;
            end
            IO_PROG: begin
                safe_state = 1'b1;
                prog_mode  = 1'b1;
            end
            default: begin
                safe_state = 1'b0;
                prog_mode  = 1'b0;
            end
        endcase
    end

    a_r11_prog_implies_safe: assert property (@(posedge tck) disable iff (!trst_n)
        prog_mode |-> safe_state);

    a_r9_safe_sticky: assert property (@(posedge tck) disable iff (!trst_n)
        (safe_state && !tlr && !(update && op_new == OP_PROG_OFF)) |=> safe_state);

    a_r8_prog_off_clears: assert property (@(posedge tck) disable iff (!trst_n)
        (update && !tlr && op_new == OP_PROG_OFF) |=> (!safe_state && !prog_mode));

    a_r3_reset_flags: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (!safe_state && !prog_mode));

endmodule

// File: rtl/tdec_shreg.sv
module tdec_shreg #(
    parameter int W    = 8,
    parameter bit HOLD = 1'b0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic         so
);

    logic [W-1:0] q;
    logic [W-1:0] load_v;

    assign load_v = HOLD ? q : cap_val;

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    q <= '0;
                end else if (clr) begin
                    q <= '0;
                end else if (en && capture) begin
                    q <= load_v;
                end else if (en && shift) begin
                    q <= tdi;
                end
            end
        end else begin : g_many
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    q <= '0;
                end else if (clr) begin
                    q <= '0;
                end else if (en && capture) begin
                    q <= load_v;
                end else if (en && shift) begin
                    q <= {tdi, q[W-1:1]};
                end
            end
        end
    endgenerate

    assign so = q[0];

endmodule

// File: rtl/tdec_dregs.sv
module tdec_dregs
    import tdec_pkg::*;
#(
    parameter int          ID_W       = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1A2B_C043,
    parameter int          STAT_W     = 12,
    parameter int          SIG_W      = 16,
    parameter int          CADDR_W    = 4,
    parameter int          CDATA_W    = 41,
    parameter int          AADDR_W    = 75,
    parameter int          ADATA_W    = 81
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              clr,
    input  dsel_e             sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [STAT_W-1:0] status_in,
    input  logic [SIG_W-1:0]  sig_in,
    output logic              so
);

    localparam logic [ID_W-1:0] ID_CAP = ID_W'(IDCODE_VAL);

    logic byp_so, id_so, stat_so, sig_so;
    logic caddr_so, cdata_so, aaddr_so, adata_so;

    tdec_shreg #(.W(1), .HOLD(1'b0)) u_byp (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_BYPASS),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val(1'b0), .so(byp_so));

    tdec_shreg #(.W(ID_W), .HOLD(1'b0)) u_id (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_IDCODE),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val(ID_CAP), .so(id_so));

    tdec_shreg #(.W(STAT_W), .HOLD(1'b0)) u_stat (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_STATUS),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val(status_in), .so(stat_so));

    tdec_shreg #(.W(SIG_W), .HOLD(1'b0)) u_sig (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_SIG),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val(sig_in), .so(sig_so));

    tdec_shreg #(.W(CADDR_W), .HOLD(1'b1)) u_caddr (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_CADDR),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val('0), .so(caddr_so));

    tdec_shreg #(.W(CDATA_W), .HOLD(1'b1)) u_cdata (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_CDATA),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val('0), .so(cdata_so));

    tdec_shreg #(.W(AADDR_W), .HOLD(1'b1)) u_aaddr (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_AADDR),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val('0), .so(aaddr_so));

    tdec_shreg #(.W(ADATA_W), .HOLD(1'b1)) u_adata (
        .tck(tck), .trst_n(trst_n), .clr(clr), .en(sel == SEL_ADATA),
        .capture(capture), .shift(shift), .tdi(tdi),
        .cap_val('0), .so(adata_so));

    always_comb begin
        unique case (sel)
            SEL_IDCODE: so = id_so;
            SEL_STATUS: so = stat_so;
            SEL_SIG:    so = sig_so;
            SEL_CADDR:  so = caddr_so;
            SEL_CDATA:  so = cdata_so;
            SEL_AADDR:  so = aaddr_so;
            SEL_ADATA:  so = adata_so;
            default:    so = byp_so;
        endcase
    end

    a_r6_bypass_capture_zero: assert property (@(posedge tck) disable iff (!trst_n)
        (capture && !clr && sel == SEL_BYPASS) |=> !byp_so);

    a_r4_status_sampled: assert property (@(posedge tck) disable iff (!trst_n)
        (capture && !clr && sel == SEL_STATUS) |=> (stat_so == $past(status_in[0])));

endmodule

// File: rtl/tap_instr_decoder.sv
module tap_instr_decoder
    import tdec_pkg::*;
#(
    parameter int          ID_W       = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1A2B_C043,
    parameter int          STAT_W     = 12,
    parameter int          SIG_W      = 16,
    parameter int          CADDR_W    = 4,
    parameter int          CDATA_W    = 41,
    parameter int          AADDR_W    = 75,
    parameter int          ADATA_W    = 81
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tlr,
    input  logic              capture_ir,
    input  logic              shift_ir,
    input  logic              update_ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              tdi,
    input  logic [STAT_W-1:0] status_in,
    input  logic [SIG_W-1:0]  sig_in,
    output logic              tdo,
    output logic              safe_state,
    output logic              prog_mode
);

    logic  ir_so;
    logic  dr_so;
    op_t   op_pending;
    op_t   op_active;
    dsel_e sel;

    tdec_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tlr(tlr),
        .capture(capture_ir), .shift(shift_ir), .update(update_ir),
        .tdi(tdi), .ir_so(ir_so),
        .op_pending(op_pending), .op_active(op_active));

    assign sel = op_to_sel(op_active);

    tdec_mode u_mode (
        .tck(tck), .trst_n(trst_n), .tlr(tlr),
        .update(update_ir && !capture_ir && !shift_ir),
        .op_new(op_pending),
        .safe_state(safe_state), .prog_mode(prog_mode));

    tdec_dregs #(
        .ID_W(ID_W), .IDCODE_VAL(IDCODE_VAL), .STAT_W(STAT_W), .SIG_W(SIG_W),
        .CADDR_W(CADDR_W), .CDATA_W(CDATA_W), .AADDR_W(AADDR_W), .ADATA_W(ADATA_W)
    ) u_dregs (
        .tck(tck), .trst_n(trst_n), .clr(tlr), .sel(sel),
        .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
        .status_in(status_in), .sig_in(sig_in), .so(dr_so));

    // R7: output retimed on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else if (shift_ir) begin
            tdo <= ir_so;
        end else if (shift_dr) begin
            tdo <= dr_so;
        end else begin
            tdo <= 1'b0;
        end
    end

endmodule

// File: tb/sim_tap_instr_decoder.sv
`timescale 1ns/1ps
module sim_tap_instr_decoder;

    localparam logic [31:0] ID_EXP = 32'h5C3E_90A7;
    localparam int NSH = 100;

    logic tck = 1'b0;
    always #2 tck = ~tck;

    logic trst_n, tlr, capture_ir, shift_ir, update_ir, capture_dr, shift_dr, tdi;
    logic [11:0] status_in;
    logic [15:0] sig_in;
    logic tdo, safe_state, prog_mode;

    tap_instr_decoder #(.IDCODE_VAL(ID_EXP)) u0 (
        .tck(tck), .trst_n(trst_n), .tlr(tlr),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
        .status_in(status_in), .sig_in(sig_in),
        .tdo(tdo), .safe_state(safe_state), .prog_mode(prog_mode));

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0]   m_op;
    bit           m_safe, m_prog;
    logic [127:0] m_hold [4];

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 0 bypass 1 id 2 status 3 sig 4 caddr 5 cdata 6 aaddr 7 adata
    function automatic int kind_of(logic [5:0] op);
        if (op[5]) return 0;
        case (op)
            6'b011001: return 1;
            6'b011011: return 2;
            6'b011110: return 3;
            6'b001010: return 4;
            6'b001011, 6'b001110: return 5;
            6'b000001: return 6;
            6'b000010, 6'b001000: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic int len_of(int k);
        case (k)
            1: return 32;  2: return 12;  3: return 16;  4: return 4;
            5: return 41;  6: return 75;  7: return 81;
            default: return 1;
        endcase
    endfunction

    function automatic string req_of(int k);
        if (k == 0) return "R6";
        if (k <= 3) return "R4";
        return "R5";
    endfunction

    function automatic bit safe_code(logic [5:0] op);
        case (op)
            6'b010111, 6'b000011, 6'b000100, 6'b000101, 6'b000110,
            6'b001100, 6'b001101, 6'b010110, 6'b011101, 6'b011111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input bit ci, input bit si, input bit ui,
                         input bit cd, input bit sd, input bit t, input logic d);
        @(posedge tck);
        #1;
        capture_ir = ci; shift_ir = si; update_ir = ui;
        capture_dr = cd; shift_dr = sd; tlr = t; tdi = d;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 1'b0);
        @(negedge tck); #1;
    endtask

    task automatic model_reset();
        m_op = 6'b011001; m_safe = 0; m_prog = 0;
        for (int i = 0; i < 4; i++) m_hold[i] = '0;
    endtask

    task automatic ir_scan(input logic [5:0] op, input bit upd);
        logic [5:0] got;
        drive(1, 0, 0, 0, 0, 0, 1'b0);
        @(negedge tck); #1;
        for (int i = 0; i < 6; i++) begin
            drive(0, 1, 0, 0, 0, 0, op[i]);
            @(negedge tck); #1;
            got[i] = tdo;
        end
        chk(got == 6'b000001, "R1 capture pattern", got, 6'b000001);
        drive(0, 0, upd, 0, 0, 0, 1'b0);
        @(negedge tck); #1;
        idle();
        chk(tdo == 1'b0, "R7 idle tdo", tdo, 0);
        if (upd) begin
            m_op = op;
            if (op == 6'b011000) begin m_safe = 1; m_prog = 1; end
            else if (op == 6'b011010) begin m_safe = 0; m_prog = 0; end
            else if (safe_code(op)) m_safe = 1;
        end
    endtask

    task automatic chk_flags(input string tag);
        chk(safe_state == m_safe, {"R8 R9 R10 safe_state ", tag}, safe_state, m_safe);
        chk(prog_mode == m_prog, {"R8 R9 R10 prog_mode ", tag}, prog_mode, m_prog);
        chk(!(prog_mode && !safe_state), "R11 prog without safe", prog_mode, 0);
    endtask

    task automatic dr_check(input string tag);
        int k, L;
        logic [127:0] din, dout, cap, exp, msk;
        k = kind_of(m_op);
        L = len_of(k);
        din = {$urandom, $urandom, $urandom, $urandom};
        status_in = 12'($urandom);
        sig_in = 16'($urandom);
        case (k)
            1: cap = 128'(ID_EXP);
            2: cap = 128'(status_in);
            3: cap = 128'(sig_in);
            4, 5, 6, 7: cap = m_hold[k-4];
            default: cap = '0;
        endcase
        drive(0, 0, 0, 1, 0, 0, 1'b0);
        @(negedge tck); #1;
        dout = '0;
        for (int i = 0; i < NSH; i++) begin
            drive(0, 0, 0, 0, 1, 0, din[i]);
            @(negedge tck); #1;
            dout[i] = tdo;
        end
        idle();
        exp = '0;
        for (int i = 0; i < NSH; i++) exp[i] = (i < L) ? cap[i] : din[i-L];
        chk(dout == exp, {req_of(k), " R7 scan ", tag}, dout, exp);
        if (k >= 4) begin
            msk = (128'd1 << L) - 128'd1;
            m_hold[k-4] = (din >> (NSH - L)) & msk;
        end
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        trst_n = 0; tlr = 0; capture_ir = 0; shift_ir = 0; update_ir = 0;
        capture_dr = 0; shift_dr = 0; tdi = 0; status_in = '0; sig_in = '0;
        model_reset();
        repeat (3) @(posedge tck);
        #1 trst_n = 1;
        @(negedge tck); #1;
        chk(tdo == 0, "R3 reset tdo", tdo, 0);
        chk_flags("after trst");
        dr_check("R3 ident after trst");

        // R2: shift without update keeps the identification path
        ir_scan(6'b011011, 1'b0);
        dr_check("R2 no update");

        // sweep every code in ascending order
        for (int c = 0; c < 64; c++) begin
            ir_scan(6'(c), 1'b1);
            chk_flags($sformatf("sweep %0d", c));
            dr_check($sformatf("sweep %0d", c));
        end

        // R9 directed: erase inside program mode keeps program mode
        ir_scan(6'b011000, 1'b1);
        ir_scan(6'b001100, 1'b1);
        chk_flags("R9 erase in prog");
        ir_scan(6'b011001, 1'b1);
        chk_flags("R10 ident in prog");
        ir_scan(6'b011010, 1'b1);
        chk_flags("R8 prog off");

        // R5 read-back twice on the same register
        ir_scan(6'b001011, 1'b1);
        dr_check("R5 fill cfg data");
        dr_check("R5 readback cfg data");

        // R3 tlr strobe clears everything
        ir_scan(6'b010111, 1'b1);
        drive(0, 0, 0, 0, 0, 1, 1'b0);
        @(negedge tck); #1;
        idle();
        model_reset();
        chk_flags("R3 after tlr");
        dr_check("R3 ident after tlr");
        ir_scan(6'b000010, 1'b1);
        dr_check("R3 array data cleared");

        // constrained random: favour the named codes
        for (int r = 0; r < 60; r++) begin
            logic [5:0] op;
            case ($urandom % 4)
                0: op = 6'b011010;
                1: op = 6'b011000;
                default: op = 6'($urandom);
            endcase
            ir_scan(op, ($urandom % 8) != 0);
            chk_flags($sformatf("rand %0d", r));
            dr_check($sformatf("rand %0d", r));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule